// File: doc/BRIEF.md
# Sequential Integer Square Root

This unit computes the integer square root of an unsigned operand, rounded down: the largest value whose square does not exceed the operand. A controller outside the block pulses `start` for one cycle to capture the operand. The block then settles one result bit per clock, beginning with the most significant bit. Each step forms a candidate with the current bit set, squares it, and compares the square against the captured operand.

Nothing is published on its own. When the iteration window has run, the controller pulses `stop` for one cycle, and that copies the working result into the output register. The output then keeps its value until the next `stop`. The operand width is a parameter. It must be even and between 4 and 64, and the result is half as wide.

Top module: `isqrt_seq`

## Requirements
- R1: With the default 32-bit operand, a `start` pulse in cycle 0 and a `stop` pulse in cycle 17 (RW+1, with RW = 16 result bits) make `root` show floor(sqrt(operand)) from the clock edge that samples `stop`.
- R2: The operand is sampled only at the edge where `start` is high. Changes on `operand` during the window do not affect the result.
- R3: Iteration lasts exactly RW cycles and settles bits from MSB to LSB. A `stop` after only RW-1 iterations returns the result with bit 0 cleared. A `stop` any time after the window returns the full result.
- R4: The bit under test stays set when the trial square is less than or equal to the operand. A perfect square n*n gives exactly n, and n*n-1 gives n-1.
- R5: `root` changes only at an edge where `stop` is high. At any other edge it holds its value, including while a new calculation runs.
- R6: Asserting `rst_n` low, asynchronously, clears every register to zero. This includes `root` and the working result, so a `stop` right after reset with no `start` yields 0.
- R7: A `stop` that arrives after only k iterations loads the partial result: floor(sqrt(operand)) with its RW-k low bits cleared. The early stop is not flagged.
- R8: A `start` during a running calculation abandons it and restarts from the new operand.
- R9: Operand width OPW is a parameter (even, 4 to 64, default 32). The result width is OPW/2, and the window scales to OPW/2 cycles. For example, an 8-bit operand gives a 4-bit result after a 4-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse: capture operand, begin calculation |
| stop | input | 1 | One-cycle pulse: load working result into `root` |
| operand | input | OPW | Unsigned operand |
| root | output | OPW/2 | Registered floor square root |

## Verification
The main function is tried with four kinds of input.

- **Fixed corner table.** The table holds zero and one, the values either side of perfect squares, a mid-range power of two, and the top of the 32-bit range. This separates a less-than compare from a less-or-equal compare, and shows whether the trial square overflows near full scale.
- **Pseudo-random operands.** These are compared against a floating-point reference, to catch bit-ordering errors that the fixed table might miss.
- **All 256 operands of an 8-bit instance.** This confirms that the width parameter and the shorter window really scale.
- **Directed timing runs.** Early stops, late stops, restarts and resets show whether the window is exactly RW cycles and whether the output moves only on `stop`.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  function automatic int unsigned root_width(input int unsigned opw);
    return opw / 2;
  endfunction

  function automatic bit width_legal(input int unsigned opw);
    return (opw % 2 == 0) && (opw >= 4) && (opw <= 64);
  endfunction

endpackage

// File: rtl/isqrt_sched.sv
module isqrt_sched #(
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [RW-1:0] bit_sel,
  output logic          busy
);

  localparam logic [RW-1:0] TOP_BIT = {1'b1, {(RW-1){1'b0}}};

  logic [RW-1:0] sel_q;
  logic [RW-1:0] sel_d;
  logic          sel_en;

  always_comb begin
    sel_en = start | (|sel_q);
    sel_d  = sel_q;
    if (start) begin
      sel_d = TOP_BIT;
    end else if (|sel_q) begin
      sel_d = sel_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign bit_sel = sel_q;
  assign busy    = |sel_q;

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  assert_start_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sel_q[RW-1] && $countones(sel_q) == 1));

  assert_walk_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && sel_q != '0) |=> (sel_q == ($past(sel_q) >> 1)));

endmodule

// File: rtl/isqrt_step.sv
module isqrt_step #(
  parameter int unsigned OPW = 32,
  parameter int unsigned RW  = OPW / 2
) (
  input  logic [OPW-1:0] opnd,
  input  logic [RW-1:0]  part,
  input  logic [RW-1:0]  bit_sel,
  output logic [RW-1:0]  part_next
);

  logic [RW-1:0]  trial;
  logic [OPW-1:0] trial_wide;
  logic [OPW-1:0] trial_sq;
  logic           keep;

  always_comb begin
    trial      = part | bit_sel;
    trial_wide = {{(OPW-RW){1'b0}}, trial};
    trial_sq   = trial_wide * trial_wide;
    keep       = (trial_sq <= opnd);
    part_next  = keep ? trial : part;
  end

endmodule

// File: rtl/isqrt_core.sv
module isqrt_core #(
  parameter int unsigned OPW = 32,
  parameter int unsigned RW  = OPW / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           busy,
  input  logic [RW-1:0]  bit_sel,
  input  logic [OPW-1:0] operand,
  output logic [RW-1:0]  part
);

  localparam int unsigned CW = OPW + 2;

  logic [OPW-1:0] op_q;
  logic [OPW-1:0] op_d;
  logic [RW-1:0]  part_q;
  logic [RW-1:0]  part_d;
  logic [RW-1:0]  step_out;
  logic           part_en;

  isqrt_step #(.OPW(OPW), .RW(RW)) u_step (
    .opnd      (op_q),
    .part      (part_q),
    .bit_sel   (bit_sel),
    .part_next (step_out)
  );

  always_comb begin
    op_d    = start ? operand : op_q;
    part_en = start | busy;
    part_d  = start ? '0 : step_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
    end else if (start) begin
      op_q <= op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
    end else if (part_en) begin
      part_q <= part_d;
    end
  end

  assign part = part_q;

  logic [CW-1:0] chk_p;
  logic [CW-1:0] chk_op;
  logic [CW-1:0] chk_sq;
  logic [CW-1:0] chk_nsq;

  always_comb begin
    chk_p   = {{(CW-RW){1'b0}}, part_q};
    chk_op  = {2'b00, op_q};
    chk_sq  = chk_p * chk_p;
    chk_nsq = (chk_p + 1'b1) * (chk_p + 1'b1);
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (op_q == $past(operand) && part_q == '0));

  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_sq <= chk_op);

  assert_final_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_nsq > chk_op));

endmodule

// File: rtl/isqrt_outreg.sv
module isqrt_outreg #(
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop,
  input  logic [RW-1:0] part,
  output logic [RW-1:0] root
);

  logic [RW-1:0] root_q;
  logic [RW-1:0] root_d;

  always_comb begin
    root_d = stop ? part : root_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
    end else if (stop) begin
      root_q <= root_d;
    end
  end

  assign root = root_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stop |=> $stable(root_q));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (root_q == $past(part)));

endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int unsigned OPW = 32,
  parameter int unsigned RW  = isqrt_pkg::root_width(OPW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic [OPW-1:0] operand,
  output logic [RW-1:0]  root
);

  generate
    if (!isqrt_pkg::width_legal(OPW)) begin : g_bad_width
      $error("isqrt_seq: OPW must be even and within 4..64");
    end
  endgenerate

  logic [RW-1:0] bit_sel;
  logic          busy;
  logic [RW-1:0] part;

  isqrt_sched #(.RW(RW)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .bit_sel (bit_sel),
    .busy    (busy)
  );

  isqrt_core #(.OPW(OPW), .RW(RW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .bit_sel (bit_sel),
    .operand (operand),
    .part    (part)
  );

  isqrt_outreg #(.RW(RW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .stop  (stop),
    .part  (part),
    .root  (root)
  );

endmodule

// File: tb/tb_isqrt_seq.sv
`timescale 1ns/1ps
module tb_isqrt_seq;

  localparam int RW = 16;
  localparam int NV = 16;
  // {operand, expected floor root}
  localparam logic [47:0] VEC [0:NV-1] = '{
    {32'h0000_0000, 16'd0},     {32'h0000_0001, 16'd1},
    {32'h0000_0002, 16'd1},     {32'h0000_0003, 16'd1},
    {32'h0000_0004, 16'd2},     {32'h0000_000C, 16'd3},
    {32'h0000_000D, 16'd3},     {32'h0000_000F, 16'd3},
    {32'h0000_0010, 16'd4},     {32'h0000_0011, 16'd4},
    {32'h000F_423F, 16'h03E7},  {32'h000F_4240, 16'h03E8},
    {32'h8000_0000, 16'hB504},  {32'hFFFE_0000, 16'hFFFE},
    {32'hFFFE_0001, 16'hFFFF},  {32'hFFFF_FFFF, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start = 1'b0, stop = 1'b0;
  logic [31:0] operand = '0;
  logic [15:0] root;
  logic        s8_start = 1'b0, s8_stop = 1'b0;
  logic [7:0]  s8_op = '0;
  logic [3:0]  s8_root;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isqrt_seq #(.OPW(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .operand(operand), .root(root));

  isqrt_seq #(.OPW(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .start(s8_start), .stop(s8_stop),
    .operand(s8_op), .root(s8_root));

  function automatic longint unsigned ref_root(input longint unsigned x);
    longint unsigned r;
    r = longint'($floor($sqrt(real'(x))));
    while (r * r > x) r--;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic check(input string tag, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic calc32(input logic [31:0] x, input int iters,
                        output logic [15:0] got);
    @(negedge clk); start = 1'b1; operand = x;
    @(negedge clk); start = 1'b0; operand = ~x;
    repeat (iters) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    got = root;
  endtask

  task automatic calc8(input logic [7:0] x, output logic [3:0] got);
    @(negedge clk); s8_start = 1'b1; s8_op = x;
    @(negedge clk); s8_start = 1'b0; s8_op = ~x;
    repeat (4) @(negedge clk);
    s8_stop = 1'b1;
    @(negedge clk); s8_stop = 1'b0;
    got = s8_root;
  endtask

  function automatic longint unsigned top_bits(input longint unsigned v,
                                               input int k);
    return v & ~((64'd1 << (RW - k)) - 1);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [3:0]  got8;
    logic [31:0] lcg;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 reset root", root, 0);
    check("R6 reset root 8-bit", s8_root, 0);
    rst_n = 1'b1;

    // R1 R2 R4: table walk (operand is inverted after start for R2)
    for (int i = 0; i < NV; i++) begin
      calc32(VEC[i][47:16], RW, got);
      check("R1/R2/R4 table", got, VEC[i][15:0]);
    end

    // R1: pseudo-random operands vs floating reference
    lcg = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      calc32(lcg, RW, got);
      check("R1 random", got, ref_root(lcg));
    end

    // R4: perfect squares and one below
    for (int n = 2; n < 65536; n += 9973) begin
      calc32(32'(n * n), RW, got);
      check("R4 exact square", got, n);
      calc32(32'(n * n - 1), RW, got);
      check("R4 square minus one", got, n - 1);
    end

    // R3: window is exactly RW cycles
    calc32(32'h000F_423F, RW - 1, got);
    check("R3 one short", got, 16'h03E6);
    calc32(32'h000F_423F, RW + 4, got);
    check("R3 late stop", got, 16'h03E7);

    // R7: early stops give top bits
    calc32(32'hFFFF_FFFF, 4, got);
    check("R7 early k=4", got, 16'hF000);
    calc32(32'h000F_4240, 8, got);
    check("R7 early k=8", got, top_bits(1000, 8));
    calc32(32'h8000_0000, 1, got);
    check("R7 early k=1", got, top_bits(46340, 1));

    // R5: output holds while a new calculation runs
    calc32(32'h000F_423F, RW, got);
    @(negedge clk); start = 1'b1; operand = 32'd16;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < RW + 3; c++) begin
      if (c % 6 == 0) check("R5 hold", root, 16'h03E7);
      @(negedge clk);
    end
    check("R5 hold after window", root, 16'h03E7);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check("R5 load on stop", root, 4);

    // R8: restart mid-calculation
    @(negedge clk); start = 1'b1; operand = 32'd13;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    calc32(32'hFFFE_0000, RW, got);
    check("R8 restart", got, 16'hFFFE);

    // R6: reset mid-window clears output and working result
    @(negedge clk); start = 1'b1; operand = 32'hFFFF_FFFF;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R6 async clear", root, 0);
    @(negedge clk); rst_n = 1'b1;
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check("R6 stop after reset", root, 0);

    // R9: exhaustive 8-bit instance, 4-cycle window
    for (int v = 0; v < 256; v++) begin
      calc8(8'(v), got8);
      check("R9 8-bit", got8, ref_root(v));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule